// File: doc/BRIEF.md
# Polarity Output Mode Controller

This block sits in the control path of a column driver that inverts drive polarity from line to line. Once per horizontal line a strobe pulse arrives. On the strobe's rising edge the block captures the polarity input and compares it with the value captured on the previous line. From that captured polarity it derives, for every channel, which half of the reference ladder the channel's converter draws from. While the strobe stays high, every output is held in one of two states. If the polarity flipped, the outputs are forced to reset. If the polarity did not flip, they are released to high impedance.

On the strobe's falling edge the block puts every channel back into drive. It also emits a one-cycle apply pulse, which tells the datapath to start driving the new gray levels. Two board-level mode pins, slew rate and output resistance, are registered and passed on as control bits. Both default high, as if pulled up. The strobe is a synchronous input sampled on the block clock. The reference ladders and the converters are outside this block.

Top module: `pol_outmode_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every channel's mode is high impedance (`10`). The stored line polarity is low, `line_apply_o` is 0, and both `slew_fast_o` and `drive_strong_o` are 1.
- R2: With stored polarity low, each odd-numbered channel (channel n is bit n-1 of `bank_hi_o`) selects the low bank (`bank_hi_o` bit = 0, V0..V7). Each even-numbered channel selects the high bank (bit = 1, V8..V15).
- R3: With stored polarity high, the bank assignment is swapped: odd channels read 1 and even channels read 0.
- R4: At a strobe rising edge where the sampled polarity differs from the stored one, all channels enter reset (`01`). The stored polarity and the bank selects update in that same clock cycle.
- R5: At a strobe rising edge where the sampled polarity equals the stored one, all channels enter high impedance (`10`).
- R6: At a strobe falling edge, all channels enter drive (`00`) and `line_apply_o` is high for exactly one cycle.
- R7: A change on `polarity_i` anywhere except at a strobe rising edge has no effect on the bank selects or on the modes.
- R8: `slew_fast_o` and `drive_strong_o` follow `slew_pin_i` and `ores_pin_i` one clock later.
- R9: The mode is identical on all channels and is never `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Line strobe, one pulse per line |
| polarity_i | input | 1 | Polarity for the next line, sampled at strobe rise |
| slew_pin_i | input | 1 | Slew-rate mode pin, 1 = high slew rate |
| ores_pin_i | input | 1 | Output-resistance mode pin, 1 = low output resistance |
| bank_hi_o | output | NUM_CH | Per-channel bank select, 1 = high bank; bit n-1 is channel n |
| mode_o | output | 2*NUM_CH | Per-channel mode, bits [2n-1:2n-2] for channel n: 00 drive, 01 reset, 10 high impedance |
| line_apply_o | output | 1 | One-cycle pulse marking the start of gray-level drive |
| slew_fast_o | output | 1 | Registered slew-rate mode |
| drive_strong_o | output | 1 | Registered output-resistance mode |

## Verification
The mode and bank selects change at the clock edge that first sees the strobe high, and the drive mode and apply pulse appear at the edge that first sees it low. The registered mode pins lag their inputs by exactly one edge. The bench changes inputs at falling clock edges and reads results at the next falling edge, so each check lands one register stage after its stimulus. One check looks a further cycle on to confirm that the apply pulse has dropped.

// File: rtl/pom_pkg.sv
// Shared types for the polarity output mode controller.
package pom_pkg;
    // Output stage mode, two bits per channel.
    typedef enum logic [1:0] {
        OM_DRIVE = 2'b00,
        OM_RESET = 2'b01,
        OM_HIZ   = 2'b10
    } out_mode_e;
endpackage

// File: rtl/pom_strobe_edge.sv
// Detects rising and falling edges of the line strobe.
// Assumes strobe_i is synchronous to clk; edges are combinational
// from the input and a one-cycle history register.
module pom_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o,
    output logic fall_o
);
    logic strb_q;

    // Keep last cycle's strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strobe_i;
    end

    assign rise_o = strobe_i & ~strb_q;
    assign fall_o = ~strobe_i & strb_q;
endmodule

// File: rtl/pom_pol_track.sv
// Holds the polarity captured at each strobe rise and flags a flip
// against the previous line. Derives per-channel bank selects:
// channel n = bit n-1; odd channels take the stored polarity,
// even channels its inverse (1 = high bank).
module pom_pol_track #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              pol_i,
    output logic              flip_o,
    output logic [NUM_CH-1:0] bank_hi_o
);
    logic pol_line_q;

    // Capture polarity only on strobe rise; reset to low.
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_line_q <= 1'b0;
        else if (rise_i) pol_line_q <= pol_i;
    end

    assign flip_o = rise_i & (pol_i != pol_line_q);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bank
        localparam int CH_NUM = i + 1;
        if (CH_NUM % 2 == 1) begin : g_odd
            assign bank_hi_o[i] = pol_line_q;
        end else begin : g_even
            assign bank_hi_o[i] = ~pol_line_q;
        end
    end
endmodule

// File: rtl/pom_mode_seq.sv
// Sequences the shared output mode across a strobe: reset or high
// impedance from rise (by flip flag), drive from fall, with a
// one-cycle apply pulse. Starts in high impedance after reset.
module pom_mode_seq
    import pom_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_i,
    input  logic      fall_i,
    input  logic      flip_i,
    output out_mode_e mode_o,
    output logic      apply_o
);
    out_mode_e mode_q;
    logic      apply_q;

    // Mode update on strobe edges.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= OM_HIZ;
        else if (rise_i) mode_q <= flip_i ? OM_RESET : OM_HIZ;
        else if (fall_i) mode_q <= OM_DRIVE;
    end

    // Apply pulse for one cycle after a falling strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) apply_q <= 1'b0;
        else        apply_q <= fall_i;
    end

    assign mode_o  = mode_q;
    assign apply_o = apply_q;
endmodule

// File: rtl/pom_pin_reg.sv
// Registers static mode pins; resets to all ones to mirror pull-ups.
module pom_pin_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Plain capture with high reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '1;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/pol_outmode_ctrl.sv
// Top: output mode control for a polarity-inverting column driver.
// Assumes one strobe pulse per line, synchronous to clk, and that
// polarity_i is settled at the cycle the strobe rises.
module pol_outmode_ctrl
    import pom_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_i,
    input  logic                polarity_i,
    input  logic                slew_pin_i,
    input  logic                ores_pin_i,
    output logic [NUM_CH-1:0]   bank_hi_o,
    output logic [2*NUM_CH-1:0] mode_o,
    output logic                line_apply_o,
    output logic                slew_fast_o,
    output logic                drive_strong_o
);
    localparam int MODE_W = 2;

    logic      rise, fall, flip;
    out_mode_e mode;
    logic [1:0] pins_q;

    pom_strobe_edge u_edge (
        .clk, .rst_n, .strobe_i, .rise_o(rise), .fall_o(fall)
    );

    pom_pol_track #(.NUM_CH(NUM_CH)) u_pol (
        .clk, .rst_n, .rise_i(rise), .pol_i(polarity_i),
        .flip_o(flip), .bank_hi_o(bank_hi_o)
    );

    pom_mode_seq u_seq (
        .clk, .rst_n, .rise_i(rise), .fall_i(fall), .flip_i(flip),
        .mode_o(mode), .apply_o(line_apply_o)
    );

    pom_pin_reg #(.W(2)) u_pins (
        .clk, .rst_n, .d_i({slew_pin_i, ores_pin_i}), .q_o(pins_q)
    );

    assign slew_fast_o    = pins_q[1];
    assign drive_strong_o = pins_q[0];

    // Fan the shared mode out to every channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_mode
        assign mode_o[MODE_W*i +: MODE_W] = mode;
    end
endmodule

// File: rtl/pom_checker.sv
// Assertion checker bound to pol_outmode_ctrl.
module pom_checker #(
    parameter int NUM_CH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                strobe_i,
    input logic [NUM_CH-1:0]   bank_hi_o,
    input logic [2*NUM_CH-1:0] mode_o,
    input logic                line_apply_o
);
    logic strb_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) strb_prev <= 1'b0;
        else        strb_prev <= strobe_i;
    end
    logic c_rise, c_fall;
    assign c_rise = strobe_i & ~strb_prev;
    assign c_fall = ~strobe_i & strb_prev;

    AST_RISE_NOT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        c_rise |=> (mode_o[1:0] == 2'b01 || mode_o[1:0] == 2'b10)); // R4
    AST_FALL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        c_fall |=> (mode_o[1:0] == 2'b00 && line_apply_o)); // R6
    AST_APPLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_apply_o |=> !line_apply_o); // R6
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rise |=> $stable(bank_hi_o)); // R7
    AST_BANK_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_hi_o[0] != bank_hi_o[1]); // R2
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[1:0] != 2'b11); // R9
    AST_MODE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == {NUM_CH{mode_o[1:0]}}); // R9
endmodule

bind pol_outmode_ctrl pom_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .bank_hi_o(bank_hi_o),
    .mode_o(mode_o), .line_apply_o(line_apply_o)
);

// File: tb/pol_outmode_ctrl_test.sv
module pol_outmode_ctrl_test;
    localparam int NUM_CH = 8;
    localparam int NLINES = 6;
    // Per line: {polarity, expected mode at rise}
    localparam logic [2:0] LINES [NLINES] = '{
        {1'b0, 2'b10}, {1'b1, 2'b01}, {1'b1, 2'b10},
        {1'b0, 2'b01}, {1'b0, 2'b10}, {1'b1, 2'b01}
    };

    logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, pol = 1'b0;
    logic slew = 1'b1, ores = 1'b1;
    logic [NUM_CH-1:0]   bank;
    logic [2*NUM_CH-1:0] mode;
    logic apply, slew_o, ores_o;
    int n_tests = 0, n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pol_outmode_ctrl #(.NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .polarity_i(pol),
        .slew_pin_i(slew), .ores_pin_i(ores), .bank_hi_o(bank),
        .mode_o(mode), .line_apply_o(apply), .slew_fast_o(slew_o),
        .drive_strong_o(ores_o)
    );

    function automatic logic [NUM_CH-1:0] exp_bank(input logic p);
        logic [NUM_CH-1:0] b;
        for (int i = 0; i < NUM_CH; i++) b[i] = ((i + 1) % 2 == 1) ? p : ~p;
        return b;
    endfunction

    function automatic logic [2*NUM_CH-1:0] exp_mode(input logic [1:0] m);
        return {NUM_CH{m}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 mode", 32'(mode), 32'(exp_mode(2'b10)));
        chk("R1 bank", 32'(bank), 32'(exp_bank(1'b0)));
        chk("R1 apply", 32'(apply), 32'd0);
        chk("R1 pins", {30'd0, slew_o, ores_o}, 32'd3);
        rst_n = 1'b1;
        tick(2);
        chk("R1 mode after release", 32'(mode), 32'(exp_mode(2'b10)));
        chk("R2 bank low polarity", 32'(bank), 32'(exp_bank(1'b0)));

        // Table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < NLINES; k++) begin
            pol = LINES[k][2];
            strobe = 1'b1;
            tick(1);
            chk(LINES[k][1:0] == 2'b01 ? "R4 flip to reset" : "R5 same to hiz",
                32'(mode), 32'(exp_mode(LINES[k][1:0])));
            chk(LINES[k][2] ? "R3 bank high polarity" : "R2 bank low polarity",
                32'(bank), 32'(exp_bank(LINES[k][2])));
            tick(2);
            chk("R5 hold during strobe", 32'(mode), 32'(exp_mode(LINES[k][1:0])));
            strobe = 1'b0;
            tick(1);
            chk("R6 drive on fall", 32'(mode), 32'(exp_mode(2'b00)));
            chk("R6 apply pulse", 32'(apply), 32'd1);
            tick(1);
            chk("R6 apply single cycle", 32'(apply), 32'd0);
            tick(2);
        end
        // Stored polarity now 1.

        // R7: polarity wiggles off the rising edge
        pol = 1'b0;
        tick(2);
        chk("R7 bank ignores polarity while low", 32'(bank), 32'(exp_bank(1'b1)));
        chk("R7 mode ignores polarity while low", 32'(mode), 32'(exp_mode(2'b00)));
        pol = 1'b1;
        strobe = 1'b1;
        tick(1);
        chk("R5 same polarity after wiggle", 32'(mode), 32'(exp_mode(2'b10)));
        pol = 1'b0;
        tick(2);
        chk("R7 bank ignores polarity while high", 32'(bank), 32'(exp_bank(1'b1)));
        chk("R7 mode ignores polarity while high", 32'(mode), 32'(exp_mode(2'b10)));
        strobe = 1'b0;
        tick(2);

        // R8: mode pins
        slew = 1'b0;
        tick(1);
        chk("R8 slew follows", {31'd0, slew_o}, 32'd0);
        chk("R8 ores unchanged", {31'd0, ores_o}, 32'd1);
        ores = 1'b0; slew = 1'b1;
        tick(1);
        chk("R8 ores follows", {30'd0, slew_o, ores_o}, 32'd2);

        // R1: reset mid-drive returns to high impedance and low polarity
        rst_n = 1'b0;
        tick(1);
        chk("R1 reset returns hiz", 32'(mode), 32'(exp_mode(2'b10)));
        chk("R1 reset returns bank", 32'(bank), 32'(exp_bank(1'b0)));
        chk("R1 reset returns pins", {30'd0, slew_o, ores_o}, 32'd3);
        rst_n = 1'b1;
        // R4: polarity high on first line after reset is a flip
        pol = 1'b1; strobe = 1'b1;
        tick(1);
        chk("R4 first line flip", 32'(mode), 32'(exp_mode(2'b01)));
        chk("R9 uniform mode", 32'(mode), 32'(exp_mode(mode[1:0])));
        strobe = 1'b0;
        tick(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule